// File: doc/BRIEF.md
# Multicycle 16-bit Stored-Program Processor Core

This block is a small processor core in which program and data live in one word-addressed memory of 16-bit words. Every access to that memory, including an instruction fetch, goes out through a memory address register and comes back through a memory data register. The core has eight general registers, a program counter, an instruction register and a three-bit condition code holding negative, zero and positive flags.

A control state machine walks each instruction through fetch, decode, address evaluation, operand fetch, execution and result store. It advances one phase per clock and skips any phase the current instruction does not need. The instruction set covers register and immediate ADD and AND, NOT, a load from a base register plus an offset, a jump to a base register plus an offset, and a conditional branch on the flags. The memory is external and synchronous: it captures the address on a clock edge and returns the word on the following cycle. A read-only observation port shows the phase, the program counter, the flags and any one selected general register.

Top module: `mc16_core`

## Requirements
- R1: While reset is asserted, and after its synchronised release, the core sits in phase code 0. The program counter equals START_ADDR and all eight general registers read 0. The flags read 3'b010, where bit 2 is negative, bit 1 is zero and bit 0 is positive. mem_we is 0.
- R2: Fetch uses phase codes 0 to 3, in order. Phase 0 copies PC into the address register, so mem_addr equals PC during phase 1. The memory word enters the data register at the end of phase 2. It moves to the instruction register, with PC incremented by 1, at the end of phase 3.
- R3: Decode is phase code 4 and selects on IR[15:12]. The remaining phases are 5 for address evaluation, 6 for memory wait, 7 for operands, 8 for execute and 9 for store. Arithmetic and logic instructions then run 7,8,9. The load runs 5,6,7,9. The jump runs 7,8. The branch runs 8. Each sequence then returns to phase 0.
- R4: ADD (opcode 4'b0001) writes register IR[8:6] plus a second operand to register IR[11:9]. When IR[5] is 0, the second operand is register IR[2:0] and IR[4:3] has no effect. When IR[5] is 1, it is IR[4:0] sign-extended.
- R5: AND (opcode 4'b0101) takes its operands the same way as ADD and writes the bitwise AND.
- R6: NOT (opcode 4'b1001) writes the complement of register IR[8:6] to register IR[11:9].
- R7: The load (opcode 4'b0110) forms the address as register IR[8:6] plus IR[5:0] zero-extended. The address appears on mem_addr during phase 6. The word read there is written to register IR[11:9].
- R8: The jump (opcode 4'b1100) sets PC to register IR[8:6] plus IR[5:0] zero-extended, at the end of phase 8. IR[11:9] has no effect.
- R9: The branch (opcode 4'b0000) is taken when IR[11:9] ANDed with the flags is non-zero. A taken branch replaces PC[8:0] with IR[8:0] and keeps the upper bits of the incremented PC. A mask of 3'b000 never branches. PC changes in no phase other than 3 and 8.
- R10: ADD, AND, NOT and the load set exactly one flag from the value written: negative when bit 15 is 1, zero when the value is 0, positive otherwise. The flags change only at the end of phase 9, so the jump and the branch leave them untouched.
- R11: Any other opcode changes no register, no flag and no PC bit beyond the fetch increment, and returns from phase 4 to phase 0.
- R12: mem_we is never asserted, so the memory is only ever read.
- R13: peek_reg combinationally shows the general register selected by peek_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchroniser |
| mem_addr | output | 16 | Memory address register contents |
| mem_wdata | output | 16 | Memory data register contents |
| mem_we | output | 1 | Memory write enable, held low |
| mem_rdata | input | 16 | Word returned by the synchronous memory one cycle after the address |
| peek_sel | input | 3 | General register index to observe |
| peek_reg | output | 16 | Contents of the selected general register |
| peek_pc | output | 16 | Program counter |
| peek_cc | output | 3 | Flags, bit 2 negative, bit 1 zero, bit 0 positive |
| phase | output | 4 | Current phase code |

## Verification
The program sums a twelve-word array in a loop that ends when a zero-flag branch is finally taken. A core with the wrong branch mask test would either never leave the loop or leave it at once, and the sum and pointer registers would disagree with the reference. The load and jump offsets have bit 5 set, so a core that sign-extends them would fetch from the wrong place or land at the wrong target. A register-mode ADD has IR[4:3] set and would pick up a bogus operand if those bits leaked into operand selection. A never-taken 3'b000 mask, an unassigned opcode and a taken branch that must keep the upper PC bits round out the corner cases. Since phases are compared on every clock, a skipped or extra phase shows up as soon as it happens.

// File: rtl/mc16_pkg.sv
`timescale 1ns/1ps
package mc16_pkg;

  typedef enum logic [3:0] {
    PH_FADDR  = 4'd0,
    PH_FWAIT  = 4'd1,
    PH_FLOAD  = 4'd2,
    PH_FIR    = 4'd3,
    PH_DECODE = 4'd4,
    PH_EVAL   = 4'd5,
    PH_MWAIT  = 4'd6,
    PH_OPND   = 4'd7,
    PH_EXEC   = 4'd8,
    PH_STORE  = 4'd9
  } phase_e;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_AND = 2'd1,
    ALU_NOT = 2'd2
  } alu_op_e;

  localparam logic [3:0] OPC_BR   = 4'h0;
  localparam logic [3:0] OPC_ADD  = 4'h1;
  localparam logic [3:0] OPC_AND  = 4'h5;
  localparam logic [3:0] OPC_LDR  = 4'h6;
  localparam logic [3:0] OPC_NOT  = 4'h9;
  localparam logic [3:0] OPC_JMPR = 4'hC;

  localparam logic [2:0] CC_RESET = 3'b010;

  function automatic logic [2:0] flags_of(input logic neg, input logic zero);
    if (neg)       return 3'b100;
    else if (zero) return 3'b010;
    else           return 3'b001;
  endfunction

endpackage

// File: rtl/mc16_alu.sv
`timescale 1ns/1ps
module mc16_alu
  import mc16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y
);

  always_comb begin
    unique case (op)
      ALU_AND: y = a & b;
      ALU_NOT: y = ~a;
      default: y = a + b;
    endcase
  end

endmodule

// File: rtl/mc16_regfile.sv
`timescale 1ns/1ps
module mc16_regfile #(
  parameter int W = 16,
  parameter int N = 8,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  input  logic [AW-1:0] raddr_c,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b,
  output logic [W-1:0]  rdata_c
);

  logic [W-1:0] regs [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    logic wr_en;
    always_comb wr_en = we && (waddr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     regs[g] <= '0;
      else if (wr_en) regs[g] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
  assign rdata_c = regs[raddr_c];

endmodule

// File: rtl/mc16_ctrl.sv
`timescale 1ns/1ps
module mc16_ctrl
  import mc16_pkg::*;
#(
  parameter int OPC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  output phase_e           phase,
  output logic             is_add,
  output logic             is_and,
  output logic             is_not,
  output logic             is_ldr,
  output logic             is_jmpr,
  output logic             is_br
);

  localparam int NOPS = 1 << OPC_W;
  localparam logic [NOPS-1:0] KNOWN =
      (NOPS'(1) << OPC_BR)  | (NOPS'(1) << OPC_ADD) | (NOPS'(1) << OPC_AND) |
      (NOPS'(1) << OPC_LDR) | (NOPS'(1) << OPC_NOT) | (NOPS'(1) << OPC_JMPR);

  logic [NOPS-1:0] hot;
  logic            known;
  phase_e          state_q, state_d;

  for (genvar g = 0; g < NOPS; g++) begin : g_dec
    assign hot[g] = (opcode == OPC_W'(g));
  end

  assign known   = |(hot & KNOWN);
  assign is_add  = hot[OPC_ADD];
  assign is_and  = hot[OPC_AND];
  assign is_not  = hot[OPC_NOT];
  assign is_ldr  = hot[OPC_LDR];
  assign is_jmpr = hot[OPC_JMPR];
  assign is_br   = hot[OPC_BR];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_FADDR:  state_d = PH_FWAIT;
      PH_FWAIT:  state_d = PH_FLOAD;
      PH_FLOAD:  state_d = PH_FIR;
      PH_FIR:    state_d = PH_DECODE;
      PH_DECODE: begin
        if (!known)      state_d = PH_FADDR;
        else if (is_ldr) state_d = PH_EVAL;
        else if (is_br)  state_d = PH_EXEC;
        else             state_d = PH_OPND;
      end
      PH_EVAL:   state_d = PH_MWAIT;
      PH_MWAIT:  state_d = PH_OPND;
      PH_OPND:   state_d = is_ldr ? PH_STORE : PH_EXEC;
      PH_EXEC:   state_d = (is_jmpr || is_br) ? PH_FADDR : PH_STORE;
      PH_STORE:  state_d = PH_FADDR;
      default:   state_d = PH_FADDR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PH_FADDR;
    else        state_q <= state_d;
  end

  assign phase = state_q;

endmodule

// File: rtl/mc16_rst_sync.sv
`timescale 1ns/1ps
module mc16_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sh <= '0;
    else           sh <= {sh[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sh[STAGES-1];

endmodule

// File: rtl/mc16_core.sv
`timescale 1ns/1ps
module mc16_core
  import mc16_pkg::*;
#(
  parameter int                WORD_W     = 16,
  parameter int                NUM_REGS   = 8,
  parameter logic [WORD_W-1:0] START_ADDR = 'h3000,
  localparam int               RSEL_W     = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic [RSEL_W-1:0] peek_sel,
  output logic [WORD_W-1:0] peek_reg,
  output logic [WORD_W-1:0] peek_pc,
  output logic [2:0]        peek_cc,
  output logic [3:0]        phase
);

  localparam int OPC_W   = 4;
  localparam int OFF_W   = 6;
  localparam int IMM_W   = 5;
  localparam int BRF_W   = 9;
  localparam int DR_LSB  = 9;
  localparam int SR1_LSB = 6;
  localparam int SR2_LSB = 0;

  logic rst_core_n;

  mc16_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_core_n)
  );

  // architectural and staging registers
  logic [WORD_W-1:0] pc_q,  pc_d;   logic pc_en;
  logic [WORD_W-1:0] mar_q, mar_d;  logic mar_en;
  logic [WORD_W-1:0] mdr_q, mdr_d;  logic mdr_en;
  logic [WORD_W-1:0] ir_q,  ir_d;   logic ir_en;
  logic [WORD_W-1:0] opa_q, opa_d;  logic opa_en;
  logic [WORD_W-1:0] opb_q, opb_d;  logic opb_en;
  logic [WORD_W-1:0] res_q, res_d;  logic res_en;
  logic [2:0]        cc_q,  cc_d;   logic cc_en;

  phase_e ph;
  logic   is_add, is_and, is_not, is_ldr, is_jmpr, is_br;

  mc16_ctrl #(.OPC_W(OPC_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .opcode  (ir_q[WORD_W-1 -: OPC_W]),
    .phase   (ph),
    .is_add  (is_add),
    .is_and  (is_and),
    .is_not  (is_not),
    .is_ldr  (is_ldr),
    .is_jmpr (is_jmpr),
    .is_br   (is_br)
  );

  // instruction fields
  logic [RSEL_W-1:0] f_dr, f_sr1, f_sr2;
  logic              f_immsel;
  logic [WORD_W-1:0] f_imm, f_off;
  logic [2:0]        f_mask;

  assign f_dr     = ir_q[DR_LSB  +: RSEL_W];
  assign f_sr1    = ir_q[SR1_LSB +: RSEL_W];
  assign f_sr2    = ir_q[SR2_LSB +: RSEL_W];
  assign f_mask   = ir_q[DR_LSB +: 3];
  assign f_immsel = ir_q[IMM_W];
  assign f_imm    = {{(WORD_W-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
  assign f_off    = {{(WORD_W-OFF_W){1'b0}}, ir_q[OFF_W-1:0]};

  // register file
  logic [WORD_W-1:0] rf_a, rf_b, rf_w;
  logic              rf_we;

  assign rf_we = (ph == PH_STORE);
  assign rf_w  = is_ldr ? mdr_q : res_q;

  mc16_regfile #(.W(WORD_W), .N(NUM_REGS)) u_rf (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .we      (rf_we),
    .waddr   (f_dr),
    .wdata   (rf_w),
    .raddr_a (f_sr1),
    .raddr_b (f_sr2),
    .raddr_c (peek_sel),
    .rdata_a (rf_a),
    .rdata_b (rf_b),
    .rdata_c (peek_reg)
  );

  // ALU
  alu_op_e           alu_op;
  logic [WORD_W-1:0] alu_y;

  always_comb begin
    if (is_and)      alu_op = ALU_AND;
    else if (is_not) alu_op = ALU_NOT;
    else             alu_op = ALU_ADD;
  end

  mc16_alu #(.W(WORD_W)) u_alu (
    .a  (opa_q),
    .b  (opb_q),
    .op (alu_op),
    .y  (alu_y)
  );

  // next-state logic
  logic br_taken;
  assign br_taken = |(f_mask & cc_q);

  always_comb begin
    pc_en = 1'b0;
    pc_d  = pc_q;
    if (ph == PH_FIR) begin
      pc_en = 1'b1;
      pc_d  = pc_q + 1'b1;
    end else if (ph == PH_EXEC && is_jmpr) begin
      pc_en = 1'b1;
      pc_d  = opa_q + f_off;
    end else if (ph == PH_EXEC && is_br && br_taken) begin
      pc_en = 1'b1;
      pc_d  = {pc_q[WORD_W-1:BRF_W], ir_q[BRF_W-1:0]};
    end
  end

  always_comb begin
    mar_en = 1'b0;
    mar_d  = mar_q;
    if (ph == PH_FADDR) begin
      mar_en = 1'b1;
      mar_d  = pc_q;
    end else if (ph == PH_EVAL) begin
      mar_en = 1'b1;
      mar_d  = rf_a + f_off;
    end
  end

  always_comb begin
    mdr_en = (ph == PH_FLOAD) || (ph == PH_OPND && is_ldr);
    mdr_d  = mem_rdata;
    ir_en  = (ph == PH_FIR);
    ir_d   = mdr_q;
    opa_en = (ph == PH_OPND) && !is_ldr;
    opa_d  = rf_a;
    opb_en = (ph == PH_OPND) && !is_ldr;
    opb_d  = f_immsel ? f_imm : rf_b;
    res_en = (ph == PH_EXEC);
    res_d  = alu_y;
    cc_en  = (ph == PH_STORE);
    cc_d   = flags_of(rf_w[WORD_W-1], rf_w == '0);
  end

  // registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  pc_q <= START_ADDR;
    else if (pc_en)   pc_q <= pc_d;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  mar_q <= '0;
    else if (mar_en)  mar_q <= mar_d;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  mdr_q <= '0;
    else if (mdr_en)  mdr_q <= mdr_d;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  ir_q <= '0;
    else if (ir_en)   ir_q <= ir_d;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  opa_q <= '0;
    else if (opa_en)  opa_q <= opa_d;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  opb_q <= '0;
    else if (opb_en)  opb_q <= opb_d;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  res_q <= '0;
    else if (res_en)  res_q <= res_d;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  cc_q <= CC_RESET;
    else if (cc_en)   cc_q <= cc_d;
  end

  // outputs
  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;
  assign mem_we    = 1'b0;
  assign peek_pc   = pc_q;
  assign peek_cc   = cc_q;
  assign phase     = ph;

endmodule

// File: rtl/mc16_core_chk.sv
`timescale 1ns/1ps
module mc16_core_chk
  import mc16_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   phase,
  input logic [W-1:0] pc,
  input logic [W-1:0] mem_addr,
  input logic [2:0]   cc
);

  AST_FETCH_MAR: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FADDR) |=> (mem_addr == $past(pc)))
    else $error("address register did not take PC"); // R2

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FIR) |=> (pc == W'($past(pc) + 1'b1)))
    else $error("PC not incremented by fetch"); // R2

  AST_DECODE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FIR) |=> (phase == PH_DECODE))
    else $error("decode does not follow fetch"); // R3

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase <= PH_STORE))
    else $error("phase code out of range"); // R3

  AST_LOAD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EVAL) |=> (phase == PH_MWAIT))
    else $error("memory wait does not follow address evaluation"); // R7

  AST_PC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_FIR && phase != PH_EXEC) |=> $stable(pc))
    else $error("PC moved outside fetch or execute"); // R9

  AST_CC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(cc) == 1))
    else $error("flags not one-hot"); // R10

  AST_CC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_STORE) |=> $stable(cc))
    else $error("flags moved outside store"); // R10

endmodule

bind mc16_core mc16_core_chk #(.W(WORD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .phase    (phase),
  .pc       (peek_pc),
  .mem_addr (mem_addr),
  .cc       (peek_cc)
);

// File: tb/sim_mc16_core.sv
`timescale 1ns/1ps
module sim_mc16_core;

  localparam logic [15:0] START = 16'h0200;
  localparam logic [15:0] HALT  = 16'h021C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we;
  logic [2:0]  peek_sel;
  logic [15:0] peek_reg, peek_pc;
  logic [2:0]  peek_cc;
  logic [3:0]  phase;

  always #2.5 clk = ~clk;

  logic [15:0] mem [4096];
  logic [15:0] ram_q;
  always @(posedge clk) ram_q <= mem[mem_addr[11:0]];
  assign mem_rdata = ram_q;

  mc16_core #(.START_ADDR(START)) u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .peek_sel(peek_sel),
    .peek_reg(peek_reg), .peek_pc(peek_pc), .peek_cc(peek_cc), .phase(phase)
  );

  int nchk = 0;
  int nfail = 0;

  // reference model state
  logic [15:0] m_pc;
  logic [15:0] m_r [8];
  logic [2:0]  m_cc;
  logic [15:0] m_fetch;
  logic [15:0] m_ld;
  string       m_req;
  int          phq[$];

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] nzp(input logic [15:0] v);
    if (v[15]) return 3'b100;
    if (v == 16'h0000) return 3'b010;
    return 3'b001;
  endfunction

  function automatic logic [15:0] e_rr(input logic [3:0] op, input int d, input int a, input int b, input logic [1:0] junk);
    return {op, 3'(d), 3'(a), 1'b0, junk, 3'(b)};
  endfunction
  function automatic logic [15:0] e_ri(input logic [3:0] op, input int d, input int a, input int imm);
    return {op, 3'(d), 3'(a), 1'b1, 5'(imm)};
  endfunction
  function automatic logic [15:0] e_not(input int d, input int a);
    return {4'h9, 3'(d), 3'(a), 6'h3F};
  endfunction
  function automatic logic [15:0] e_ldr(input int d, input int b, input int off);
    return {4'h6, 3'(d), 3'(b), 6'(off)};
  endfunction
  function automatic logic [15:0] e_jmpr(input int b, input int off);
    return {4'hC, 3'b000, 3'(b), 6'(off)};
  endfunction
  function automatic logic [15:0] e_br(input logic [2:0] mask, input logic [15:0] tgt);
    return {4'h0, mask, tgt[8:0]};
  endfunction

  task automatic model_step();
    logic [15:0] w, b, v;
    w = mem[m_pc[11:0]];
    m_fetch = m_pc;
    m_pc = m_pc + 16'd1;
    for (int p = 0; p < 5; p++) phq.push_back(p);
    case (w[15:12])
      4'h1, 4'h5: begin
        b = w[5] ? {{11{w[4]}}, w[4:0]} : m_r[w[2:0]];
        v = (w[15:12] == 4'h1) ? m_r[w[8:6]] + b : m_r[w[8:6]] & b;
        m_r[w[11:9]] = v;
        m_cc = nzp(v);
        phq.push_back(7); phq.push_back(8); phq.push_back(9);
        m_req = (w[15:12] == 4'h1) ? "R4" : "R5";
      end
      4'h9: begin
        v = ~m_r[w[8:6]];
        m_r[w[11:9]] = v;
        m_cc = nzp(v);
        phq.push_back(7); phq.push_back(8); phq.push_back(9);
        m_req = "R6";
      end
      4'h6: begin
        m_ld = m_r[w[8:6]] + {10'b0, w[5:0]};
        v = mem[m_ld[11:0]];
        m_r[w[11:9]] = v;
        m_cc = nzp(v);
        phq.push_back(5); phq.push_back(6); phq.push_back(7); phq.push_back(9);
        m_req = "R7";
      end
      4'hC: begin
        m_pc = m_r[w[8:6]] + {10'b0, w[5:0]};
        phq.push_back(7); phq.push_back(8);
        m_req = "R8";
      end
      4'h0: begin
        if ((w[11:9] & m_cc) != 3'b000) m_pc = {m_pc[15:9], w[8:0]};
        phq.push_back(8);
        m_req = "R9";
      end
      default: m_req = "R11";
    endcase
  endtask

  task automatic cmp_arch();
    chk(m_req, "pc", peek_pc, m_pc);
    chk("R10", "flags", {13'b0, peek_cc}, {13'b0, m_cc});
    for (int i = 0; i < 8; i++) begin
      peek_sel = 3'(i);
      #0.1;
      chk({m_req, " R13"}, $sformatf("r%0d", i), peek_reg, m_r[i]);
    end
  endtask

  initial begin
    int cyc;
    int ex;
    string tag;
    rst_n = 1'b0;
    peek_sel = 3'd0;
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
    // data
    mem[12'h030] = 16'h0400;
    mem[12'h031] = 16'd12;
    mem[12'h032] = 16'h01F8;
    mem[12'h033] = 16'h0000;
    for (int i = 0; i < 12; i++) mem[12'h400 + i] = 16'(i + 1);
    // program
    mem[12'h200] = e_ri(4'h5, 3, 3, 0);
    mem[12'h201] = e_ldr(1, 0, 6'h30);
    mem[12'h202] = e_ldr(2, 0, 6'h31);
    mem[12'h203] = e_br(3'b010, 16'h0209);
    mem[12'h204] = e_ldr(4, 1, 0);
    mem[12'h205] = e_rr(4'h1, 3, 3, 4, 2'b11);
    mem[12'h206] = e_ri(4'h1, 1, 1, 1);
    mem[12'h207] = e_ri(4'h1, 2, 2, -1);
    mem[12'h208] = e_br(3'b111, 16'h0203);
    mem[12'h209] = e_not(5, 3);
    mem[12'h20A] = e_rr(4'h1, 6, 5, 3, 2'b00);
    mem[12'h20B] = e_rr(4'h5, 7, 6, 3, 2'b00);
    mem[12'h20C] = e_ri(4'h1, 5, 5, 15);
    mem[12'h20D] = e_ri(4'h5, 6, 6, -16);
    mem[12'h20E] = e_br(3'b001, 16'h0300);
    mem[12'h20F] = e_br(3'b100, 16'h0211);
    mem[12'h210] = e_ri(4'h1, 0, 0, 1);
    mem[12'h211] = 16'hD000;
    mem[12'h212] = e_ldr(4, 0, 6'h32);
    mem[12'h213] = e_jmpr(4, 6'h22);
    for (int i = 12'h214; i < 12'h21A; i++) mem[i] = e_ri(4'h1, 0, 0, 1);
    mem[12'h21A] = e_br(3'b000, 16'h021C);
    mem[12'h21B] = e_ldr(0, 0, 6'h33);
    mem[12'h21C] = e_br(3'b111, HALT);

    m_pc = START;
    m_cc = 3'b010;
    for (int i = 0; i < 8; i++) m_r[i] = 16'h0000;
    m_req = "R1";

    repeat (3) @(negedge clk);
    chk("R1", "phase in reset", {12'b0, phase}, 16'd0);
    chk("R1", "pc in reset", peek_pc, START);
    chk("R1", "flags in reset", {13'b0, peek_cc}, 16'd2);
    chk("R1", "mem_we in reset", {15'b0, mem_we}, 16'd0);
    for (int i = 0; i < 8; i++) begin
      peek_sel = 3'(i);
      #0.1;
      chk("R1", $sformatf("r%0d in reset", i), peek_reg, 16'h0000);
    end

    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);

    cyc = 0;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (cyc > 20000) begin
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual=%0d cycles expected=halt reached", cyc);
        break;
      end
      if (phq.size() == 0) begin
        cmp_arch();
        if (m_pc == HALT) break;
        model_step();
      end
      ex = phq.pop_front();
      tag = (ex < 4) ? "R2" : {"R3 ", m_req};
      chk(tag, "phase", {12'b0, phase}, 16'(ex));
      if (ex == 1) chk("R2", "fetch address", mem_addr, m_fetch);
      if (ex == 6) chk("R7", "load address", mem_addr, m_ld);
      chk("R12", "mem_we", {15'b0, mem_we}, 16'd0);
    end

    chk("R4", "final sum", m_r[3], 16'd78);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule